// File: doc/BRIEF.md
# Per-Slave Bus Arbiter with Parking and Slot Limit

This block decides which of up to sixteen bus masters owns one slave port of an on-chip bus matrix. Every cycle it looks at the masters' request lines and at a burst-end pulse from the slave side. It drives a registered one-hot grant vector, the index of the owner, and a valid flag. Ownership changes only at arbitration points. These are the end of a burst and the expiry of a per-slave slot counter, which cuts a burst that runs too long. When the slave has no owner, any request is an arbitration point.

A small write-only configuration port holds the settings. The control word selects round-robin or fixed-priority selection. It also holds the slot length in cycles and one of three parking policies for a slave that falls idle. Under the first policy the slave disconnects, so the next requester pays one cycle. Under the second, the last owner stays connected. Under the third, a fixed default master is connected. Further words hold a 4-bit priority for each master.

Configuration changes never disturb a burst in progress. They are used at the next arbitration point, and the slot length is captured each time a grant is made.

Top module: `slv_arbiter`

## Requirements
- R1: After reset, grant is all zero and owner_vld is low. The configuration holds a slot limit of 16, the disconnect parking policy and round-robin selection, and every priority is 0.
- R2: When bit 16 of the control word (address 0) is 1, each arbitration picks the requesting master with the largest 4-bit priority, and a tie goes to the lowest index. The priority of master i sits at bits [4*(i%8)+3 : 4*(i%8)] of the word at address 1 + i/8.
- R3: When bit 16 of the control word is 0, each arbitration picks the first requester found by searching upward from the index after the last granted master, wrapping past the top. Priorities have no effect, and after reset the search begins at master 0.
- R4: While a burst is in progress, grant and owner_idx stay constant unless a burst_end pulse arrives or the slot limit is reached. At such a point, masters other than the current owner are considered first.
- R5: Bits [7:0] of the control word give the slot limit L. If L is not 0 and another master is waiting, the owner keeps the grant for exactly L cycles and the grant then moves. If L is 0, there is no limit.
- R6: Parking field bits [9:8] = 0 (3 behaves the same): when an arbitration point finds no request, grant drops to zero. A master that requests afterwards sees its grant one cycle later.
- R7: Parking field = 1: when an arbitration point finds no request, grant stays with the last owner. If that owner requests again, its grant is already asserted in the same cycle.
- R8: Parking field = 2: when an arbitration point finds no request, grant moves to the master whose index is in bits [15:12] of the control word. If that index is not below the number of masters, grant drops to zero.
- R9: Writes to the control word or to the priority words in the middle of a burst do not change the owner. The slot limit in force is the one captured when the current grant was made.
- R10: grant has at most one bit set. owner_vld is high exactly when grant is nonzero, and owner_idx is then the index of that bit.
- R11: At an arbitration point where only the current owner is requesting, it keeps the grant and starts a fresh slot.
- R12: A burst_end pulse while no burst is in progress (disconnected or parked) has no effect.
- R13: Grants are registered: a request seen while the slave is free produces a grant in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_MST | Request line per master |
| burst_end | input | 1 | Pulse from the slave port: the current burst has finished |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Word address: 0 control, 1 and up priority words |
| cfg_wdata | input | 32 | Configuration write data |
| grant | output | N_MST | One-hot grant to the owning or parked master |
| owner_idx | output | IDX_W | Index of the granted master |
| owner_vld | output | 1 | High when any grant bit is set |

## Verification
The bench sweeps every request pattern against each possible previous round-robin owner, and against several priority sets that include ties. A wrong wrap point or a search that starts at the wrong place would pick the wrong master, and a tie broken upward would favour a higher index. For the slot counter, the bench counts the exact cycle of the hand-over at the reset limit and at a limit of 3, where an off-by-one would grant one cycle early or late. It also holds a burst for 40 cycles with the limit at 0. For each parking policy, it samples the grant in the same cycle a master re-requests, which separates the extra cycle of the disconnect policy from the zero latency of the other two. It also confirms that an out-of-range fixed index disconnects, and that a slot length written mid-burst is only used after the next grant.

// File: rtl/slvarb_pkg.sv
`timescale 1ns/1ps
package slvarb_pkg;
  // control word field placement (address 0)
  localparam int CTL_SLOT_LSB = 0;
  localparam int CTL_PARK_LSB = 8;
  localparam int CTL_FIX_LSB  = 12;
  localparam int CTL_ARB_BIT  = 16;
  localparam int FIX_W        = 4;
  localparam int PARK_W       = 2;
  localparam logic [31:0] CTL_RESET = 32'h0000_0010;

  typedef enum logic [PARK_W-1:0] {
    PARK_DROP  = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_FIXED = 2'd2,
    PARK_SPARE = 2'd3
  } park_e;
endpackage

// File: rtl/slvarb_cfg.sv
`timescale 1ns/1ps
module slvarb_cfg import slvarb_pkg::*; #(
  parameter int N_MST  = 16,
  parameter int PRIO_W = 4,
  parameter int SLOT_W = 8,
  parameter int NPW    = 2,
  parameter int CFG_AW = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr,
  input  logic [CFG_AW-1:0]         addr,
  input  logic [31:0]               wdata,
  output logic [SLOT_W-1:0]         slot_lim,
  output logic [PARK_W-1:0]         park_mode,
  output logic [FIX_W-1:0]          fix_idx,
  output logic                      arb_prio,
  output logic [N_MST*PRIO_W-1:0]   prio_flat
);
  logic [NPW*32-1:0] words_q;

  // control word
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_lim  <= CTL_RESET[CTL_SLOT_LSB +: SLOT_W];
      park_mode <= CTL_RESET[CTL_PARK_LSB +: PARK_W];
      fix_idx   <= CTL_RESET[CTL_FIX_LSB +: FIX_W];
      arb_prio  <= CTL_RESET[CTL_ARB_BIT];
    end else if (wr && addr == '0) begin
      slot_lim  <= wdata[CTL_SLOT_LSB +: SLOT_W];
      park_mode <= wdata[CTL_PARK_LSB +: PARK_W];
      fix_idx   <= wdata[CTL_FIX_LSB +: FIX_W];
      arb_prio  <= wdata[CTL_ARB_BIT];
    end
  end

  // priority words, eight 4-bit fields per word
  always_ff @(posedge clk) begin
    if (rst) begin
      words_q <= '0;
    end else if (wr) begin
      for (int w = 0; w < NPW; w++) begin
        if (addr == CFG_AW'(w + 1)) words_q[w*32 +: 32] <= wdata;
      end
    end
  end

  assign prio_flat = words_q[N_MST*PRIO_W-1:0];
endmodule

// File: rtl/slvarb_pick.sv
`timescale 1ns/1ps
module slvarb_pick #(
  parameter int N_MST  = 16,
  parameter int PRIO_W = 4,
  parameter int IDX_W  = 4
) (
  input  logic [N_MST-1:0]        cand,
  input  logic [N_MST*PRIO_W-1:0] prio_flat,
  input  logic [IDX_W-1:0]        last_idx,
  input  logic                    use_prio,
  output logic                    any,
  output logic [IDX_W-1:0]        win_idx
);
  logic              rr_found, pr_found;
  logic [IDX_W-1:0]  rr_idx, pr_idx;
  logic [PRIO_W-1:0] pr_best;

  // rotating search beginning after the previous winner
  always_comb begin
    int j_ix;
    rr_found = 1'b0;
    rr_idx   = '0;
    for (int k = 1; k <= N_MST; k++) begin
      j_ix = int'(last_idx) + k;
      if (j_ix >= N_MST) j_ix = j_ix - N_MST;
      if (!rr_found && cand[IDX_W'(j_ix)]) begin
        rr_found = 1'b1;
        rr_idx   = IDX_W'(j_ix);
      end
    end
  end

  // largest value wins, strict compare keeps the lowest index on ties
  always_comb begin
    pr_found = 1'b0;
    pr_idx   = '0;
    pr_best  = '0;
    for (int i = 0; i < N_MST; i++) begin
      if (cand[i] && (!pr_found || prio_flat[i*PRIO_W +: PRIO_W] > pr_best)) begin
        pr_found = 1'b1;
        pr_idx   = IDX_W'(i);
        pr_best  = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end

  assign any     = |cand;
  assign win_idx = use_prio ? pr_idx : rr_idx;
endmodule

// File: rtl/slvarb_slot.sv
`timescale 1ns/1ps
module slvarb_slot #(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              run,
  input  logic [SLOT_W-1:0] lim_in,
  output logic              expire
);
  logic [SLOT_W-1:0] cnt_q, lim_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (load) begin
      cnt_q <= '0;
      lim_q <= lim_in;
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire = run && (lim_q != '0) && (cnt_q == lim_q - 1'b1);
endmodule

// File: rtl/slv_arbiter.sv
`timescale 1ns/1ps
module slv_arbiter import slvarb_pkg::*; #(
  parameter  int N_MST  = 16,
  parameter  int PRIO_W = 4,
  parameter  int SLOT_W = 8,
  localparam int IDX_W  = (N_MST > 1) ? $clog2(N_MST) : 1,
  localparam int NPW    = (N_MST * PRIO_W + 31) / 32,
  localparam int CFG_AW = $clog2(NPW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_MST-1:0]  req,
  input  logic              burst_end,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [N_MST-1:0]  grant,
  output logic [IDX_W-1:0]  owner_idx,
  output logic              owner_vld
);
  logic [SLOT_W-1:0]       slot_lim;
  logic [PARK_W-1:0]       park_mode;
  logic [FIX_W-1:0]        fix_idx;
  logic                    arb_prio;
  logic [N_MST*PRIO_W-1:0] prio_flat;

  logic [N_MST-1:0] gnt_q, gnt_d, cand;
  logic [IDX_W-1:0] idx_q, idx_d, rr_last_q, rr_last_d, win_idx;
  logic             vld_q, vld_d, busy_q, busy_d;
  logic             pick_any, slot_load, slot_expire, arb_pt, keep_owner, fix_ok;

  slvarb_cfg #(.N_MST(N_MST), .PRIO_W(PRIO_W), .SLOT_W(SLOT_W), .NPW(NPW), .CFG_AW(CFG_AW)) u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .slot_lim(slot_lim), .park_mode(park_mode), .fix_idx(fix_idx),
    .arb_prio(arb_prio), .prio_flat(prio_flat)
  );

  // during a burst the owner yields to other requesters first
  assign cand = busy_q ? (req & ~gnt_q) : req;

  slvarb_pick #(.N_MST(N_MST), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
    .cand(cand), .prio_flat(prio_flat), .last_idx(rr_last_q),
    .use_prio(arb_prio), .any(pick_any), .win_idx(win_idx)
  );

  slvarb_slot #(.SLOT_W(SLOT_W)) u_slot (
    .clk(clk), .rst(rst), .load(slot_load), .run(busy_q),
    .lim_in(slot_lim), .expire(slot_expire)
  );

  assign arb_pt     = busy_q ? (burst_end | slot_expire) : 1'b1;
  assign keep_owner = busy_q && |(req & gnt_q);
  assign fix_ok     = 32'(fix_idx) < 32'(N_MST);

  always_comb begin
    gnt_d     = gnt_q;
    idx_d     = idx_q;
    vld_d     = vld_q;
    busy_d    = busy_q;
    rr_last_d = rr_last_q;
    slot_load = 1'b0;
    if (arb_pt) begin
      if (pick_any) begin
        gnt_d     = '0;
        gnt_d[win_idx] = 1'b1;
        idx_d     = win_idx;
        vld_d     = 1'b1;
        busy_d    = 1'b1;
        rr_last_d = win_idx;
        slot_load = 1'b1;
      end else if (keep_owner) begin
        busy_d    = 1'b1;
        slot_load = 1'b1;
      end else if (busy_q) begin
        busy_d = 1'b0;
        if (park_mode == PARK_LAST) begin
          gnt_d = gnt_q;
        end else if (park_mode == PARK_FIXED && fix_ok) begin
          gnt_d = '0;
          gnt_d[IDX_W'(fix_idx)] = 1'b1;
          idx_d = IDX_W'(fix_idx);
          vld_d = 1'b1;
        end else begin
          gnt_d = '0;
          idx_d = '0;
          vld_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q     <= '0;
      idx_q     <= '0;
      vld_q     <= 1'b0;
      busy_q    <= 1'b0;
      rr_last_q <= IDX_W'(N_MST - 1);
    end else begin
      gnt_q     <= gnt_d;
      idx_q     <= idx_d;
      vld_q     <= vld_d;
      busy_q    <= busy_d;
      rr_last_q <= rr_last_d;
    end
  end

  assign grant     = gnt_q;
  assign owner_idx = idx_q;
  assign owner_vld = vld_q;
endmodule

// File: rtl/slvarb_chk.sv
`timescale 1ns/1ps
module slvarb_chk #(
  parameter int N_MST = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [N_MST-1:0] req,
  input logic             burst_end,
  input logic [N_MST-1:0] grant,
  input logic [IDX_W-1:0] owner_idx,
  input logic             owner_vld,
  input logic             busy,
  input logic             expire,
  input logic [1:0]       park
);
  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> (grant == '0 && !owner_vld));

  // R10
  onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));

  // R10
  vld_match_chk: assert property (@(posedge clk) disable iff (rst) owner_vld == (grant != '0));

  // R10
  idx_match_chk: assert property (@(posedge clk) disable iff (rst) owner_vld |-> grant[owner_idx]);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !burst_end && !expire) |=> ($stable(grant) && $stable(owner_idx)));

  // R5
  slot_cut_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && expire && ((req & ~grant) != '0)) |=> (grant != $past(grant)));

  // R6
  drop_park_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && burst_end && req == '0 && park == 2'd0) |=> (grant == '0));
endmodule

bind slv_arbiter slvarb_chk #(.N_MST(N_MST), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .req(req), .burst_end(burst_end),
  .grant(grant), .owner_idx(owner_idx), .owner_vld(owner_vld),
  .busy(busy_q), .expire(slot_expire), .park(park_mode)
);

// File: tb/sim_slv_arbiter.sv
`timescale 1ns/1ps
module sim_slv_arbiter;
  localparam int N  = 4;
  localparam int AW = 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req = '0;
  logic          burst_end = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [N-1:0]  grant;
  logic [1:0]    owner_idx;
  logic          owner_vld;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] prio_word = '0;
  logic [N-1:0] held;

  slv_arbiter #(.N_MST(N), .PRIO_W(4), .SLOT_W(8)) u0 (
    .clk(clk), .rst(rst), .req(req), .burst_end(burst_end),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .grant(grant), .owner_idx(owner_idx), .owner_vld(owner_vld)
  );

  always #5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [AW-1:0] a, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_wr = 1'b0;
  endtask

  function automatic logic [31:0] ctl(input int slot, input int park, input int fix, input int arb);
    return 32'(slot) | (32'(park) << 8) | (32'(fix) << 12) | (32'(arb) << 16);
  endfunction

  task automatic set_prio(input logic [31:0] w);
    wr_cfg(1, w);
    prio_word = w;
  endtask

  task automatic go_idle();
    req = '0; burst_end = 1'b1;
    tick();
    burst_end = 1'b0;
  endtask

  function automatic int rr_win(input int last, input int pat);
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (last + k) % N;
      if (pat[j]) return j;
    end
    return -1;
  endfunction

  function automatic int pr_win(input logic [31:0] w, input int pat);
    int best = -1;
    int bv = -1;
    for (int i = 0; i < N; i++) begin
      if (pat[i]) begin
        int v;
        v = int'((w >> (4 * i)) & 32'hF);
        if (v > bv) begin bv = v; best = i; end
      end
    end
    return best;
  endfunction

  function automatic logic [31:0] pset(input int s);
    case (s)
      0: return 32'h0000_0000;
      1: return 32'h0000_1234;
      2: return 32'h0000_7275;
      default: return 32'h0000_F00F;
    endcase
  endfunction

  task automatic run_tests();
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    check("R1 grant after reset", 32'(grant), 0);
    check("R1 owner_vld after reset", 32'(owner_vld), 0);

    // R1 / R13 / R5 default slot of 16 and first search at master 0
    req = 4'b0011;
    tick();
    check("R13 grant one cycle after request", 32'(grant), 32'b0001);
    repeat (15) tick();
    check("R1 default slot still held at cycle 16", 32'(grant), 32'b0001);
    tick();
    check("R5 default slot hand-over at cycle 17", 32'(grant), 32'b0010);
    go_idle();

    // R3 round-robin sweep, priorities set but ignored
    wr_cfg(0, ctl(0, 0, 0, 0));
    set_prio(32'h0000_1234);
    for (int p = 0; p < N; p++) begin
      for (int pat = 1; pat < (1 << N); pat++) begin
        int w;
        req = N'(1 << p);
        tick();
        go_idle();
        req = N'(pat);
        tick();
        w = rr_win(p, pat);
        check("R3 round-robin winner", 32'(grant), 32'(1 << w));
        check("R10 owner index", 32'(owner_idx), 32'(w));
        go_idle();
      end
    end

    // R2 fixed-priority sweep
    wr_cfg(0, ctl(0, 0, 0, 1));
    for (int s = 0; s < 4; s++) begin
      set_prio(pset(s));
      for (int pat = 1; pat < (1 << N); pat++) begin
        int w;
        req = N'(pat);
        tick();
        w = pr_win(prio_word, pat);
        check("R2 priority winner", 32'(grant), 32'(1 << w));
        check("R10 owner valid", 32'(owner_vld), 1);
        go_idle();
      end
    end

    // R4 hold during a burst
    wr_cfg(0, ctl(0, 0, 0, 0));
    req = 4'b0001;
    tick();
    req = 4'b1111;
    repeat (5) tick();
    check("R4 owner held mid-burst", 32'(grant), 32'b0001);
    burst_end = 1'b1; tick(); burst_end = 1'b0;
    check("R4 others first at burst end", 32'(grant), 32'b0010);
    check("R10 owner index after switch", 32'(owner_idx), 1);

    // R11 sole requester keeps ownership
    go_idle();
    wr_cfg(0, ctl(3, 0, 0, 0));
    req = 4'b0100;
    tick();
    repeat (5) tick();
    check("R11 sole owner kept across slot expiry", 32'(grant), 32'b0100);
    burst_end = 1'b1; tick(); burst_end = 1'b0;
    check("R11 sole owner kept at burst end", 32'(grant), 32'b0100);

    // R5 slot of 3 cycles
    go_idle();
    req = 4'b0011;
    tick();
    tick(); tick();
    check("R5 owner held for 3 cycles", 32'(grant), 32'b0001);
    tick();
    check("R5 hand-over after 3 cycles", 32'(grant), 32'b0010);
    tick(); tick();
    check("R5 second owner held for 3 cycles", 32'(grant), 32'b0010);
    tick();
    check("R5 hand-back after 3 cycles", 32'(grant), 32'b0001);

    // R5 slot 0 disables the limit
    wr_cfg(0, ctl(0, 0, 0, 0));
    go_idle();
    req = 4'b0011;
    tick();
    held = grant;
    repeat (40) tick();
    check("R5 zero slot never cuts", 32'(grant), 32'(held));
    check("R5 zero slot owner valid", 32'(owner_vld), 1);

    // R9 mid-burst configuration writes
    go_idle();
    req = 4'b0001;
    tick();
    req = 4'b0011;
    set_prio(32'h0000_0050);
    wr_cfg(0, ctl(2, 0, 0, 1));
    repeat (3) tick();
    check("R9 owner kept after mid-burst writes", 32'(grant), 32'b0001);
    burst_end = 1'b1; tick(); burst_end = 1'b0;
    check("R9 switch at burst end", 32'(grant), 32'b0010);
    tick(); tick();
    check("R9 new slot length used after next grant", 32'(grant), 32'b0001);

    // R6 disconnect parking, one-cycle penalty
    wr_cfg(0, ctl(0, 0, 0, 0));
    go_idle();
    check("R6 grant dropped when idle", 32'(grant), 0);
    req = 4'b0100;
    check("R6 no grant in the request cycle", 32'(grant), 0);
    tick();
    check("R6 grant one cycle later", 32'(grant), 32'b0100);

    // R7 last-owner parking
    wr_cfg(0, ctl(0, 1, 0, 0));
    go_idle();
    check("R7 last owner stays parked", 32'(grant), 32'b0100);
    check("R7 parked owner valid", 32'(owner_vld), 1);
    burst_end = 1'b1; tick(); burst_end = 1'b0;
    check("R12 burst end while parked ignored", 32'(grant), 32'b0100);
    req = 4'b0100;
    check("R7 returning owner already granted", 32'(grant), 32'b0100);
    tick();
    go_idle();
    req = 4'b1000;
    tick();
    check("R7 other master takes parked slave", 32'(grant), 32'b1000);

    // R8 fixed default parking
    wr_cfg(0, ctl(0, 2, 1, 0));
    go_idle();
    check("R8 parked on fixed master 1", 32'(grant), 32'b0010);
    check("R8 owner index of fixed master", 32'(owner_idx), 1);
    wr_cfg(0, ctl(0, 2, 9, 0));
    req = 4'b0001;
    tick();
    go_idle();
    check("R8 out-of-range fixed index disconnects", 32'(grant), 0);
    burst_end = 1'b1; tick(); burst_end = 1'b0;
    check("R12 burst end while idle ignored", 32'(grant), 0);
  endtask

  initial begin
    fork
      begin
        run_tests();
      end
      begin
        repeat (60000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule